// File: doc/BRIEF.md
# Timer Output Compare Unit

This block watches a 16-bit free-running counter. When the count equals a programmed 16-bit compare value, it copies a chosen level onto an output pin latch and raises a compare flag. Software programs the block through a small byte-wide register bus. That bus reaches the control bits, the status flag and the two halves of the compare value.

Writing the compare value is a two-step operation. Once the upper byte has been written, compares stop until the lower byte arrives. As a result, a half-updated compare value can never cause an event. Clearing the flag is also two-step. A status read must first see the flag set. A later access to the lower compare byte then removes it. The counter advances by one on each clock where the tick input is high.

Top module: `ocmp_unit`

## Requirements
- R1: The counter resets to 0, increments by one on each clock with `tick` high, holds when `tick` is low, and wraps from 16'hFFFF to 0.
- R2: On every clock where compares are enabled and the count equals the compare value, a compare event occurs and the flag (status bit 0) is 1 after that edge.
- R3: On each compare event, the output-level bit (control bit 0) is loaded into `cmp_out`. This happens even when the flag is already 1.
- R4: A write to the upper compare byte disables compares from the next cycle onward. While disabled, `cmp_out` and the flag are not changed by the count passing any value. A write to the lower compare byte re-enables compares from the following cycle.
- R5: Reset does not alter the compare bytes. After reset, compares stay disabled until the lower compare byte is first written.
- R6: A status read that sees the flag at 1 arms the clear. The next read or write of the lower compare byte then clears the flag. An access to the lower byte without arming leaves the flag unchanged.
- R7: If a compare event falls in the same cycle as the clearing access, the flag stays at 1.
- R8: `irq` is 1 exactly when the flag is 1 and the interrupt enable (control bit 1) is 1.
- R9: The register map is as follows. `addr` 0 is control (bit 0 level, bit 1 interrupt enable, other bits read 0). Address 1 is status (bit 0 flag, other bits read 0). Address 2 is compare bits 15:8. Address 3 is compare bits 7:0. `rdata` shows the addressed register combinationally.
- R10: Reset clears `cmp_out`, the control bits and the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Counter advance enable |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (used for flag arming and clearing) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| count | output | 16 | Free-running counter value |
| cmp_out | output | 1 | Output compare pin latch |
| irq | output | 1 | Compare interrupt request |

## Verification
The compare function is exercised in four ways:
- With a running counter crossing a target, which shows that the level is latched only at the match.
- With the counter held on the target, so that a match recurs every cycle. This separates the "flag kept on a coinciding clear" case from an ordinary clear.
- With an upper-byte write followed by the counter sweeping past the stale value, which shows that inhibited compares change nothing.
- Across a full wrap and a mid-run reset, which shows counter wrap, retention of the compare bytes and the inhibit after reset.

The lower-byte accesses are issued both with and without a prior status read. This distinguishes an armed clear from an unarmed access.

// File: rtl/ocmp_unit.sv
module ocmp_unit #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [1:0]       addr,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  output logic [CNT_W-1:0] count,
  output logic             cmp_out,
  output logic             irq
);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_CMPH = 2'd2;
  localparam logic [1:0] A_CMPL = 2'd3;
  localparam int LO_W = CNT_W / 2;

  logic [CNT_W-1:0]      cnt;
  logic [CNT_W-LO_W-1:0] cmp_hi;
  logic [LO_W-1:0]       cmp_lo;
  logic lvl, ien, flag, armed, inhibit, out_q;

  wire ctrl_wr = wr_en && addr == A_CTRL;
  wire hi_wr   = wr_en && addr == A_CMPH;
  wire lo_wr   = wr_en && addr == A_CMPL;
  wire lo_acc  = (wr_en || rd_en) && addr == A_CMPL;
  wire stat_rd = rd_en && addr == A_STAT;
  wire match   = !inhibit && cnt == {cmp_hi, cmp_lo};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (hi_wr) cmp_hi <= wdata[CNT_W-LO_W-1:0];
    if (lo_wr) cmp_lo <= wdata[LO_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     inhibit <= 1'b1;
    else if (hi_wr) inhibit <= 1'b1;
    else if (lo_wr) inhibit <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lvl <= 1'b0;
      ien <= 1'b0;
    end else if (ctrl_wr) begin
      lvl <= wdata[0];
      ien <= wdata[1];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     out_q <= 1'b0;
    else if (match) out_q <= lvl;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      flag <= match || (flag && !(armed && lo_acc));
      if (lo_acc)              armed <= 1'b0;
      else if (stat_rd && flag) armed <= 1'b1;
    end

  always_comb
    case (addr)
      A_CTRL:  rdata = {6'b0, ien, lvl};
      A_STAT:  rdata = {7'b0, flag};
      A_CMPH:  rdata = 8'(cmp_hi);
      default: rdata = 8'(cmp_lo);
    endcase

  assign count   = cnt;
  assign cmp_out = out_q;
  assign irq     = flag && ien;

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt == ($past(cnt) + 1'b1));
  // R1
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
  // R2
  match_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag);
  // R3
  level_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> out_q == $past(lvl));
  // R4
  inhibit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> $stable(out_q));
  // R6
  clear_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(armed && lo_acc));
  // R7
  clear_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match && armed && lo_acc) |=> flag);
endmodule

// File: tb/ocmp_unit_tb_top.sv
module ocmp_unit_tb_top;
  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0, rd_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic [15:0] count;
  logic cmp_out, irq;

  ocmp_unit dut_i (.clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .count(count), .cmp_out(cmp_out), .irq(irq));

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit live = 0, done = 0;

  logic [15:0] m_cnt, m_cmp;
  bit m_inh, m_flag, m_arm, m_lvl, m_ien, m_out, hit, lacc, nflag;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_inh = 1; m_flag = 0; m_arm = 0; m_lvl = 0; m_ien = 0; m_out = 0;
    end else begin
      hit   = !m_inh && m_cnt == m_cmp;
      lacc  = (wr_en || rd_en) && addr == 2'd3;
      nflag = hit || (m_flag && !(m_arm && lacc));
      if (lacc) m_arm = 0;
      else if (rd_en && addr == 2'd1 && m_flag) m_arm = 1;
      m_flag = nflag;
      if (hit) m_out = m_lvl;
      if (wr_en && addr == 2'd0) begin m_lvl = wdata[0]; m_ien = wdata[1]; end
      if (wr_en && addr == 2'd2) begin m_cmp[15:8] = wdata; m_inh = 1; end
      if (wr_en && addr == 2'd3) begin m_cmp[7:0] = wdata; m_inh = 0; end
      if (tick) m_cnt = m_cnt + 16'd1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (live && !done) begin
    chk("R1 count", count, m_cnt);
    chk("R3 cmp_out", cmp_out, m_out);
    chk("R8 irq", irq, m_flag && m_ien);
    case (addr)
      2'd0: chk("R9 rdata ctrl", rdata, {6'b0, m_ien, m_lvl});
      2'd1: chk("R9 rdata status", rdata, {7'b0, m_flag});
      2'd2: chk("R9 rdata cmp hi", rdata, m_cmp[15:8]);
      default: chk("R9 rdata cmp lo", rdata, m_cmp[7:0]);
    endcase
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); #1; wr_en = 1; addr = a; wdata = d;
    @(negedge clk); #1; wr_en = 0; addr = 0; wdata = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); #1; rd_en = 1; addr = a;
    @(negedge clk); d = rdata; #1; rd_en = 0; addr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic [15:0] c;
    @(negedge clk); live = 1;
    idle(2); #1; rst_n = 1;
    idle(1);
    chk("R10 cmp_out after reset", cmp_out, 0);
    chk("R10 irq after reset", irq, 0);
    chk("R1 count after reset", count, 0);
    rd(2'd0, d); chk("R10 control after reset", d, 0);
    rd(2'd1, d); chk("R10 flag after reset", d, 0);
    wr(2'd0, 8'hFF); rd(2'd0, d); chk("R9 control unused bits", d, 8'h03);
    wr(2'd0, 8'h03);
    wr(2'd2, 8'h00); wr(2'd3, 8'h05);
    #1; tick = 1; idle(12); #1; tick = 0;
    chk("R3 level latched on match", cmp_out, 1);
    chk("R2 flag raised by match", irq, 1);
    wr(2'd0, 8'h01);
    chk("R8 irq masked", irq, 0);
    rd(2'd3, d); wr(2'd0, 8'h03);
    chk("R6 unarmed low access keeps flag", irq, 1);
    rd(2'd1, d); chk("R6 status sees flag", d[0], 1);
    rd(2'd3, d);
    chk("R6 armed low access clears flag", irq, 0);
    wr(2'd0, 8'h02);
    wr(2'd2, 8'h00); wr(2'd3, 8'h30); wr(2'd2, 8'h00);
    #1; tick = 1; idle(60); #1; tick = 0;
    chk("R4 no output change while inhibited", cmp_out, 1);
    chk("R4 no flag while inhibited", irq, 0);
    wr(2'd3, 8'h60);
    #1; tick = 1; idle(40); #1; tick = 0;
    chk("R4 compare resumes after low write", cmp_out, 0);
    chk("R2 flag after resumed match", irq, 1);
    wr(2'd0, 8'h03);
    c = count;
    wr(2'd2, c[15:8]); wr(2'd3, c[7:0] + 8'd4);
    #1; tick = 1; idle(10); #1; tick = 0;
    chk("R3 level latched with flag already set", cmp_out, 1);
    c = count;
    wr(2'd2, c[15:8]); wr(2'd3, c[7:0]); idle(2);
    rd(2'd1, d); rd(2'd3, d);
    rd(2'd1, d); chk("R7 flag kept on coinciding clear", d[0], 1);
    wr(2'd3, c[7:0] + 8'h40);
    rd(2'd1, d); rd(2'd3, d);
    rd(2'd1, d); chk("R6 flag cleared after match stops", d[0], 0);
    #1; tick = 1;
    for (int i = 0; i < 70000 && count != 16'hFFFF; i++) @(negedge clk);
    chk("R1 count reached top", count, 16'hFFFF);
    @(negedge clk);
    chk("R1 count wraps to zero", count, 0);
    #1; tick = 0;
    wr(2'd2, 8'h00); wr(2'd3, 8'h03);
    @(negedge clk); #1; rst_n = 0;
    idle(2); #1; rst_n = 1;
    #1; tick = 1; idle(8); #1; tick = 0;
    rd(2'd1, d); chk("R5 compares inhibited after reset", d[0], 0);
    rd(2'd2, d); chk("R5 high byte kept over reset", d, 8'h00);
    rd(2'd3, d); chk("R5 low byte kept over reset", d, 8'h03);
    wr(2'd3, 8'h0C);
    #1; tick = 1; idle(10); #1; tick = 0;
    rd(2'd1, d); chk("R2 match after first low write", d[0], 1);
    idle(2);
    finish_run();
  end
endmodule